// File: doc/BRIEF.md
# Banked ROM Card Select Decoder

This block is the selection logic for a 32K-byte read-only memory card on a 16-bit address bus. Up to sixteen 2K-byte sockets sit in one half of the address space, and the configuration inputs choose which half. Software turns banks on and off by writing a bank mask byte to a fixed I/O port. The card takes part in a memory cycle only when one of its configured banks is active in that mask. Bank checking can be switched off, and then the card answers on address alone.

Pairs of adjacent sockets can be shadowed, which leaves a 4K hole in which the card does not drive the data bus. A socket that is not shadowed but holds no device still drives the bus and reads as all ones. During DMA, an optional override forces the card in or out whatever the bank mask holds. Each socket has its own program-enable setting, and a write reaches a socket only when its setting is on. The card can also ask for one wait state in every cycle that selects it.

The outputs are a one-hot socket select, the byte offset for the sockets, a data-bus drive enable with the read byte, per-socket write strobes, a board-active indicator and a wait request. The storage itself, the programming pulse timing and the power control are not part of this block.

Top module: `rom_card_decode`

## Requirements
- R1: An I/O write (`io_wr`=1) to port 8'h40 loads `io_data` into the bank mask at the next rising clock edge, with bit n enabling bank n. A write to any other port leaves the mask unchanged.
- R2: With `cfg_bank_en`=1, `board_active` is 1 exactly when the bank mask and `cfg_bank_member` share at least one set bit.
- R3: With `cfg_bank_en`=0, `board_active` is 1 and the mask and membership settings have no effect on selection.
- R4: A socket is selected only when `mem_addr[15]` equals `cfg_half`. The value 1 means 8000h–FFFFh and 0 means 0000h–7FFFh.
- R5: `mem_addr[14:11]` picks socket 0 to 15, with socket 0 at the lowest 2K of the half. `socket_sel` is one-hot or zero, and `sock_offset` equals `mem_addr[10:0]`.
- R6: Setting bit k of `cfg_shadow` removes sockets 2k and 2k+1. An access to either socket selects nothing, drives nothing and requests no wait state.
- R7: A read of an unshadowed, selected socket whose `sock_present` bit is 0 drives the bus (`bus_drive`=1) with FFh. A read of a socket that holds a device returns that socket's byte. When `bus_drive` is 0, `bus_rdata` is 0.
- R8: When `cfg_dma_ovr_en`=1 and `dma_cycle`=1, the card takes part in the cycle if `cfg_dma_in`=1 and stays out if it is 0, whatever the bank mask holds.
- R9: A write strobes `sock_wr_stb` bit n only when socket n is selected and `cfg_prog_en[n]`=1. Writes to a protected socket produce no strobe.
- R10: `wait_req` is 1 when `cfg_wait_en`=1 and a socket is selected, and it is 0 otherwise.
- R11: After reset the bank mask is 8'h01, so a card that is a member of bank 0 is active at once.
- R12: A memory cycle is a cycle with `mem_rd` or `mem_wr` set. With neither set, no socket is selected and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 8 | I/O port number |
| io_data | input | 8 | I/O write data |
| mem_addr | input | 16 | Memory address |
| mem_rd | input | 1 | Memory read cycle |
| mem_wr | input | 1 | Memory write cycle |
| dma_cycle | input | 1 | Current cycle is run by a DMA master |
| cfg_bank_en | input | 1 | Bank checking enable |
| cfg_bank_member | input | 8 | Banks this card belongs to |
| cfg_half | input | 1 | Address half the card occupies |
| cfg_dma_ovr_en | input | 1 | DMA override enable |
| cfg_dma_in | input | 1 | Override direction: 1 forces in, 0 forces out |
| cfg_shadow | input | 8 | Per-pair shadow settings |
| cfg_prog_en | input | 16 | Per-socket program enables |
| cfg_wait_en | input | 1 | Wait-state enable |
| sock_present | input | 16 | Socket holds a device |
| sock_rdata | input | 128 | Read byte of each socket (socket n at bits 8n+7:8n) |
| socket_sel | output | 16 | One-hot socket select |
| sock_offset | output | 11 | Byte offset inside the socket |
| sock_wr_stb | output | 16 | Per-socket write strobe |
| bus_drive | output | 1 | Data bus drive enable |
| bus_rdata | output | 8 | Byte for the data bus |
| board_active | output | 1 | Bank match indicator |
| wait_req | output | 1 | Wait-state request |

## Verification
The assertions assume that a memory cycle is never a read and a write at once, and that all configuration inputs and socket data are settled before the cycle is sampled. The stimulus holds `mem_rd` and `mem_wr` mutually exclusive and changes inputs only on the falling clock edge. Random settings, addresses and bank masks are mixed with directed cases: two overlapping membership sets in disjoint banks, shadowed pairs next to empty sockets, and DMA override against an inactive bank and an active one. I/O writes to the bank port are interleaved with writes to other ports, so the mask update can be told apart from unrelated traffic.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

  // Non-zero overlap between an enable mask and a membership set.
  function automatic logic any_overlap(input logic [63:0] mask,
                                       input logic [63:0] member);
    return |(mask & member);
  endfunction

  // Bank state after the override during DMA.
  function automatic logic resolve_active(input logic bank_ok,
                                          input logic dma,
                                          input logic ovr_en,
                                          input logic force_in);
    return (dma && ovr_en) ? force_in : bank_ok;
  endfunction

endpackage

// File: rtl/rcd_bank_latch.sv
module rcd_bank_latch #(
  parameter int unsigned BANKS = 8,
  parameter int unsigned PORT_W = 8,
  parameter logic [PORT_W-1:0] BANK_PORT = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  input  logic [BANKS-1:0]  io_data,
  input  logic              bank_en,
  input  logic [BANKS-1:0]  member,
  output logic              bank_ok
);
  import rcd_pkg::*;

  localparam logic [BANKS-1:0] RESET_MASK = BANKS'(1);

  logic [BANKS-1:0] mask_q;
  logic             port_hit;

  assign port_hit = io_wr && (io_port == BANK_PORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= RESET_MASK;
    else if (port_hit) mask_q <= io_data;
  end

  assign bank_ok = bank_en ? any_overlap(64'(mask_q), 64'(member)) : 1'b1;

  assert_mask_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    port_hit |=> mask_q == $past(io_data));

  assert_mask_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !port_hit |=> $stable(mask_q));

  assert_bank_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_en |-> bank_ok);

endmodule

// File: rtl/rcd_socket_decode.sv
module rcd_socket_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SOCK_BITS = 4,
  localparam int unsigned NSOCK = 1 << SOCK_BITS,
  localparam int unsigned NPAIR = NSOCK / 2,
  localparam int unsigned OFF_W = ADDR_W - 1 - SOCK_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 cfg_half,
  input  logic [NPAIR-1:0]     cfg_shadow,
  input  logic                 req,
  output logic [NSOCK-1:0]     sel,
  output logic [SOCK_BITS-1:0] idx,
  output logic                 shadowed,
  output logic [OFF_W-1:0]     offset
);
  logic in_half;

  assign idx      = addr[ADDR_W-2 -: SOCK_BITS];
  assign offset   = addr[OFF_W-1:0];
  assign in_half  = addr[ADDR_W-1] == cfg_half;
  assign shadowed = cfg_shadow[idx[SOCK_BITS-1:1]];

  for (genvar g = 0; g < NSOCK; g++) begin : g_sel
    assign sel[g] = req && in_half && !shadowed && (idx == SOCK_BITS'(g));
  end

  assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  assert_shadow_hole_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shadow[addr[ADDR_W-2 -: SOCK_BITS] >> 1] |-> sel == '0);

  assert_half_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel) |-> addr[ADDR_W-1] == cfg_half);

endmodule

// File: rtl/rcd_data_gate.sv
module rcd_data_gate #(
  parameter int unsigned NSOCK = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSOCK-1:0]        sel,
  input  logic                    rd,
  input  logic                    wr,
  input  logic [NSOCK-1:0]        prog_en,
  input  logic [NSOCK-1:0]        present,
  input  logic [NSOCK*DATA_W-1:0] rdata_flat,
  input  logic                    wait_en,
  output logic                    bus_drive,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic [NSOCK-1:0]        wr_stb,
  output logic                    wait_req
);
  logic any_sel;

  assign any_sel   = |sel;
  assign bus_drive = rd && any_sel;
  assign wr_stb    = {NSOCK{wr}} & sel & prog_en;
  assign wait_req  = wait_en && any_sel;

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      for (int i = 0; i < NSOCK; i++) begin
        if (sel[i]) bus_rdata = present[i] ? rdata_flat[i*DATA_W +: DATA_W] : '1;
      end
    end
  end

  assert_write_protect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb & ~prog_en) == '0);

  assert_wait_needs_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req |-> (wait_en && sel != '0));

  assert_empty_reads_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive && (sel & ~present) != '0) |-> bus_rdata == '1);

endmodule

// File: rtl/rom_card_decode.sv
module rom_card_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SOCK_BITS = 4,
  parameter int unsigned BANKS = 8,
  parameter int unsigned PORT_W = 8,
  parameter logic [PORT_W-1:0] BANK_PORT = 8'h40,
  localparam int unsigned NSOCK = 1 << SOCK_BITS,
  localparam int unsigned NPAIR = NSOCK / 2,
  localparam int unsigned OFF_W = ADDR_W - 1 - SOCK_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    io_wr,
  input  logic [PORT_W-1:0]       io_port,
  input  logic [DATA_W-1:0]       io_data,
  input  logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_rd,
  input  logic                    mem_wr,
  input  logic                    dma_cycle,
  input  logic                    cfg_bank_en,
  input  logic [BANKS-1:0]        cfg_bank_member,
  input  logic                    cfg_half,
  input  logic                    cfg_dma_ovr_en,
  input  logic                    cfg_dma_in,
  input  logic [NPAIR-1:0]        cfg_shadow,
  input  logic [NSOCK-1:0]        cfg_prog_en,
  input  logic                    cfg_wait_en,
  input  logic [NSOCK-1:0]        sock_present,
  input  logic [NSOCK*DATA_W-1:0] sock_rdata,
  output logic [NSOCK-1:0]        socket_sel,
  output logic [OFF_W-1:0]        sock_offset,
  output logic [NSOCK-1:0]        sock_wr_stb,
  output logic                    bus_drive,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    board_active,
  output logic                    wait_req
);
  import rcd_pkg::*;

  logic                 bank_ok;
  logic                 cycle_req;
  logic                 eff_active;
  logic [SOCK_BITS-1:0] sock_idx;
  logic                 pair_shadowed;

  rcd_bank_latch #(
    .BANKS(BANKS), .PORT_W(PORT_W), .BANK_PORT(BANK_PORT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port),
    .io_data(io_data[BANKS-1:0]), .bank_en(cfg_bank_en),
    .member(cfg_bank_member), .bank_ok(bank_ok)
  );

  assign board_active = bank_ok;
  assign eff_active   = resolve_active(bank_ok, dma_cycle, cfg_dma_ovr_en, cfg_dma_in);
  assign cycle_req    = (mem_rd || mem_wr) && eff_active;

  rcd_socket_decode #(
    .ADDR_W(ADDR_W), .SOCK_BITS(SOCK_BITS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(mem_addr), .cfg_half(cfg_half),
    .cfg_shadow(cfg_shadow), .req(cycle_req), .sel(socket_sel),
    .idx(sock_idx), .shadowed(pair_shadowed), .offset(sock_offset)
  );

  rcd_data_gate #(
    .NSOCK(NSOCK), .DATA_W(DATA_W)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .sel(socket_sel), .rd(mem_rd), .wr(mem_wr),
    .prog_en(cfg_prog_en), .present(sock_present), .rdata_flat(sock_rdata),
    .wait_en(cfg_wait_en), .bus_drive(bus_drive), .bus_rdata(bus_rdata),
    .wr_stb(sock_wr_stb), .wait_req(wait_req)
  );

  assert_dma_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_cycle && cfg_dma_ovr_en && !cfg_dma_in) |-> (socket_sel == '0 && !bus_drive));

  assert_shadow_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_shadowed |-> (!bus_drive && !wait_req));

  assert_idle_no_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd && !mem_wr) |-> (socket_sel == '0 && !bus_drive));

  assert_sel_matches_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|socket_sel) |-> socket_sel[sock_idx]);

endmodule

// File: tb/tb_rom_card_decode.sv
`timescale 1ns/1ps
module tb_rom_card_decode;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         io_wr = 1'b0;
  logic [7:0]   io_port = '0;
  logic [7:0]   io_data = '0;
  logic [15:0]  mem_addr = '0;
  logic         mem_rd = 1'b0;
  logic         mem_wr = 1'b0;
  logic         dma_cycle = 1'b0;
  logic         cfg_bank_en = 1'b0;
  logic [7:0]   cfg_bank_member = '0;
  logic         cfg_half = 1'b0;
  logic         cfg_dma_ovr_en = 1'b0;
  logic         cfg_dma_in = 1'b0;
  logic [7:0]   cfg_shadow = '0;
  logic [15:0]  cfg_prog_en = '0;
  logic         cfg_wait_en = 1'b0;
  logic [15:0]  sock_present = '1;
  logic [127:0] sock_rdata = '0;
  logic [15:0]  socket_sel;
  logic [10:0]  sock_offset;
  logic [15:0]  sock_wr_stb;
  logic         bus_drive;
  logic [7:0]   bus_rdata;
  logic         board_active;
  logic         wait_req;

  int checks = 0;
  int fails = 0;
  logic [7:0] m_mask;

  always #2.5 clk = ~clk;

  rom_card_decode dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port), .io_data(io_data),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .dma_cycle(dma_cycle),
    .cfg_bank_en(cfg_bank_en), .cfg_bank_member(cfg_bank_member), .cfg_half(cfg_half),
    .cfg_dma_ovr_en(cfg_dma_ovr_en), .cfg_dma_in(cfg_dma_in), .cfg_shadow(cfg_shadow),
    .cfg_prog_en(cfg_prog_en), .cfg_wait_en(cfg_wait_en), .sock_present(sock_present),
    .sock_rdata(sock_rdata), .socket_sel(socket_sel), .sock_offset(sock_offset),
    .sock_wr_stb(sock_wr_stb), .bus_drive(bus_drive), .bus_rdata(bus_rdata),
    .board_active(board_active), .wait_req(wait_req)
  );

  function automatic logic exp_active();
    logic hit = 1'b0;
    if (!cfg_bank_en) return 1'b1;
    for (int b = 0; b < 8; b++) if (m_mask[b] && cfg_bank_member[b]) hit = 1'b1;
    return hit;
  endfunction

  function automatic int exp_sock();
    return (int'(mem_addr) / 2048) % 16;
  endfunction

  function automatic logic exp_taken();
    logic part;
    int s;
    s = exp_sock();
    if (dma_cycle && cfg_dma_ovr_en) part = cfg_dma_in;
    else part = exp_active();
    return (mem_rd || mem_wr) && part && ((mem_addr >= 16'h8000) == cfg_half)
           && !cfg_shadow[s / 2];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int s;
    logic t;
    logic [15:0] e_sel;
    logic [7:0] e_rd;
    s = exp_sock();
    t = exp_taken();
    e_sel = t ? (16'h1 << s) : 16'h0;
    e_rd = 8'h00;
    if (t && mem_rd) e_rd = sock_present[s] ? sock_rdata[s*8 +: 8] : 8'hFF;
    check("R2", "board_active", 32'(board_active), 32'(exp_active()));
    check("R5", "socket_sel", 32'(socket_sel), 32'(e_sel));
    check("R5", "sock_offset", 32'(sock_offset), 32'(mem_addr % 2048));
    check("R7", "bus_drive", 32'(bus_drive), 32'(t && mem_rd));
    check("R7", "bus_rdata", 32'(bus_rdata), 32'(e_rd));
    check("R9", "sock_wr_stb", 32'(sock_wr_stb),
          32'((t && mem_wr && cfg_prog_en[s]) ? (16'h1 << s) : 16'h0));
    check("R10", "wait_req", 32'(wait_req), 32'(t && cfg_wait_en));
  endtask

  task automatic io_write(input logic [7:0] port, input logic [7:0] data);
    @(negedge clk);
    io_wr = 1'b1; io_port = port; io_data = data;
    @(posedge clk);
    if (port == 8'h40) m_mask = data;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic access(input logic [15:0] a, input logic rd, input logic wr);
    @(negedge clk);
    mem_addr = a; mem_rd = rd; mem_wr = wr;
    #1;
    compare_all();
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_mask = 8'h01;
    for (int i = 0; i < 16; i++) sock_rdata[i*8 +: 8] = 8'(8'h30 + i);
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11: bank 0 active after reset, board in bank 0 responds
    cfg_bank_en = 1'b1; cfg_bank_member = 8'h01; cfg_half = 1'b1; cfg_wait_en = 1'b1;
    access(16'h8000, 1'b1, 1'b0);
    check("R11", "reset mask bank0", 32'(board_active), 32'h1);
    check("R11", "reset read socket0", 32'(bus_rdata), 32'h30);
    check("R4", "sock0 in upper half", 32'(socket_sel), 32'h1);
    access(16'h7FFF, 1'b1, 1'b0);
    check("R4", "lower half ignored", 32'(socket_sel), 32'h0);
    access(16'hF800, 1'b0, 1'b0);
    check("R12", "idle no select", 32'(socket_sel), 32'h0);

    // R1 / R2: overlapping boards in disjoint banks: member {2,3}
    cfg_bank_member = 8'h0C;
    io_write(8'h40, 8'h04);
    access(16'hE123, 1'b1, 1'b0);
    check("R2", "bank2 active", 32'(board_active), 32'h1);
    io_write(8'h40, 8'h30);
    access(16'hE123, 1'b1, 1'b0);
    check("R2", "banks4-5 inactive", 32'(bus_drive), 32'h0);
    io_write(8'h41, 8'h08);
    access(16'hE123, 1'b1, 1'b0);
    check("R1", "other port ignored", 32'(board_active), 32'h0);
    io_write(8'h40, 8'h08);
    access(16'hE123, 1'b1, 1'b0);
    check("R1", "mask reloaded", 32'(board_active), 32'h1);

    // R3: banking disabled
    cfg_bank_en = 1'b0; cfg_bank_member = 8'h00;
    access(16'h9000, 1'b1, 1'b0);
    check("R3", "bank off responds", 32'(bus_drive), 32'h1);

    // R6 / R7: shadowed pair vs empty socket
    cfg_shadow = 8'h10;
    sock_present = 16'hFDFF;
    access(16'hC000, 1'b1, 1'b0);
    check("R6", "shadow sock8 floats", 32'(bus_drive), 32'h0);
    access(16'hC800, 1'b1, 1'b0);
    check("R6", "shadow sock9 floats", 32'(wait_req), 32'h0);
    cfg_shadow = 8'h00;
    access(16'hC800, 1'b1, 1'b0);
    check("R7", "empty drives", 32'(bus_drive), 32'h1);
    check("R7", "empty reads FF", 32'(bus_rdata), 32'hFF);
    sock_present = '1;

    // R8: DMA override against inactive and active bank
    cfg_bank_en = 1'b1; cfg_bank_member = 8'h02;
    io_write(8'h40, 8'h01);
    cfg_dma_ovr_en = 1'b1; cfg_dma_in = 1'b1; dma_cycle = 1'b1;
    access(16'hA000, 1'b1, 1'b0);
    check("R8", "dma IN forces in", 32'(bus_drive), 32'h1);
    io_write(8'h40, 8'h02);
    cfg_dma_in = 1'b0;
    access(16'hA000, 1'b1, 1'b0);
    check("R8", "dma OUT forces out", 32'(bus_drive), 32'h0);
    dma_cycle = 1'b0;
    access(16'hA000, 1'b1, 1'b0);
    check("R8", "no dma uses bank", 32'(bus_drive), 32'h1);
    cfg_dma_ovr_en = 1'b0;

    // R9: write protect
    cfg_prog_en = 16'h0010;
    access(16'hA000, 1'b0, 1'b1);
    check("R9", "socket4 strobed", 32'(sock_wr_stb), 32'h0010);
    access(16'hA800, 1'b0, 1'b1);
    check("R9", "socket5 protected", 32'(sock_wr_stb), 32'h0);
    cfg_wait_en = 1'b0;
    access(16'hA000, 1'b1, 1'b0);
    check("R10", "no wait when off", 32'(wait_req), 32'h0);

    // Random vectors
    for (int n = 0; n < 4000; n++) begin
      int kind;
      @(negedge clk);
      kind = int'($urandom % 4);
      mem_rd = (kind == 1); mem_wr = (kind == 2);
      mem_addr = 16'($urandom);
      dma_cycle = 1'($urandom);
      if (n % 16 == 0) begin
        cfg_bank_en = ($urandom % 4) != 0;
        cfg_bank_member = 8'($urandom);
        cfg_half = 1'($urandom);
        cfg_dma_ovr_en = 1'($urandom);
        cfg_dma_in = 1'($urandom);
        cfg_shadow = 8'($urandom) & 8'($urandom);
        cfg_prog_en = 16'($urandom);
        cfg_wait_en = 1'($urandom);
        sock_present = 16'($urandom) | 16'($urandom);
        sock_rdata = {$urandom, $urandom, $urandom, $urandom};
      end
      io_wr = ($urandom % 8) == 0;
      io_port = (($urandom % 2) == 0) ? 8'h40 : 8'($urandom);
      io_data = 8'($urandom);
      #1;
      compare_all();
      @(posedge clk);
      if (io_wr && io_port == 8'h40) m_mask = io_data;
    end
    @(negedge clk);
    io_wr = 1'b0; mem_rd = 1'b0; mem_wr = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule